// File: doc/BRIEF.md
# Handset power-mode sequencer

This block is the power-mode state machine inside a handset's energy-management controller. It runs on the 32 kHz sleep clock. It receives the main and backup battery states as digital threshold flags, and it takes four wake sources: the power key, charger attach, a clock pulse on the accessory bus and an RTC alarm. From these it drives the regulator enable, the regulator sleep control, the main reference oscillator enable, the 32 kHz oscillator/RTC enable and the active-low system reset.

Software controls two transitions out of the on state: deep sleep and power-down. Software chooses whether power-down keeps the RTC running. The block never powers the system up when a battery is inserted; only a wake trigger does that. Losing the main battery drops the block to a holding mode from any state. Power-up passes through a timed start-up stage. That stage waits for the regulators and the RF clock to report ready, then counts a fixed delay before it releases the system reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (no supply), and reg_en_o, reg_sleep_o, tcxo_en_o, osc32_en_o and sys_rst_no are all 0.
- R2: The mode codes are 0 no supply, 1 backup, 2 off-warm, 3 off-cold, 4 start-up, 5 on, 6 deep sleep. If main_ok_i is low at a clock edge, the next mode is 1 when bkup_ok_i is high and 0 otherwise. This holds from every mode and takes priority over every request.
- R3: When main_ok_i is high, mode 0 moves to 3 and mode 1 moves to 2 on the next edge. Neither mode ever moves to start-up on battery presence alone.
- R4: Each mode fixes the outputs. osc32_en_o is 1 in modes 1, 2, 4, 5 and 6. reg_en_o is 1 in modes 4, 5 and 6. reg_sleep_o is 1 only in mode 6. sys_rst_no is 1 only in modes 5 and 6. tcxo_en_o is 1 in modes 4 and 5, and in mode 6 only after a wake event.
- R5: In modes 2 and 3, a rising edge on pwr_key_i, chg_det_i or acc_clk_i enters start-up on the third clock edge after the input rises, because of a two-stage synchroniser. A one-cycle rtc_alarm_i pulse enters start-up on the next edge in mode 2 and has no effect in mode 3.
- R6: Start-up enters mode 5 on the DLY_CYC-th consecutive edge (default 524) at which reg_rdy_i and rfclk_rdy_i are both high. Any edge at which either input is low restarts the count.
- R7: A held wake input gives exactly one event. A wake input in mode 5 does not change the mode.
- R8: Mode 6 is entered only from mode 5, on sw_sleep_i. sw_sleep_i has no effect in any other mode.
- R9: In mode 6, a wake event (key, charger, accessory or RTC alarm) raises tcxo_en_o. The block returns to mode 5 only at an edge where osc_rdy_i is also high.
- R10: In mode 5, sw_off_i moves the block to mode 3 when sw_off_cold_i is 1 and to mode 2 otherwise. If sw_off_i and sw_sleep_i arrive in the same cycle, sw_off_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz sleep clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_ok_i | input | 1 | Main battery above master-reset threshold |
| bkup_ok_i | input | 1 | Backup battery adequate |
| pwr_key_i | input | 1 | Power key level, asynchronous |
| chg_det_i | input | 1 | Charger attached level, asynchronous |
| acc_clk_i | input | 1 | Accessory-bus clock line, asynchronous |
| rtc_alarm_i | input | 1 | RTC alarm pulse, synchronous |
| reg_rdy_i | input | 1 | Regulators stable |
| rfclk_rdy_i | input | 1 | RF clock stable |
| osc_rdy_i | input | 1 | Reference oscillator stable |
| sw_sleep_i | input | 1 | Software deep-sleep request pulse |
| sw_off_i | input | 1 | Software power-down request pulse |
| sw_off_cold_i | input | 1 | Power-down also stops RTC/oscillator |
| mode_o | output | 3 | Current mode code |
| reg_en_o | output | 1 | Regulator enable |
| reg_sleep_o | output | 1 | Regulators in sleep mode |
| tcxo_en_o | output | 1 | Main reference oscillator enable |
| osc32_en_o | output | 1 | 32 kHz oscillator and RTC enable |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
Two pairs of events can fall in the same cycle. The first pair is battery loss and a software request. The bench drives main_ok_i low in the same cycle as sw_off_i and expects backup mode, not an off mode. The second pair is power-down and deep sleep. The bench pulses sw_off_i and sw_sleep_i together in the on mode and expects the off mode that sw_off_cold_i selects. Randomised rounds then remove and restore the battery at arbitrary points, including during start-up, and fire a randomly chosen wake source each time. Bench functions predict the next mode from the mode observed before each step.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    M_NOSUP    = 3'd0,
    M_BACKUP   = 3'd1,
    M_OFF_WARM = 3'd2,
    M_OFF_COLD = 3'd3,
    M_START    = 3'd4,
    M_ON       = 3'd5,
    M_SLEEP    = 3'd6
  } pmode_e;
endpackage

// File: rtl/pwr_edge_sync.sv
module pwr_edge_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] ev_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q, d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        d_q  <= 1'b0;
      end else begin
        s1_q <= in_i[g];
        s2_q <= s1_q;
        d_q  <= s2_q;
      end
    end
    assign ev_o[g] = s2_q & ~d_q;

    // R7
    single_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_o[g] |=> !ev_o[g]);
  end
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int unsigned DLY_CYC = 524
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rdy_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DLY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || !rdy_i) cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i & rdy_i & (cnt_q == LAST);

  // R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned DLY_CYC = 524
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_ok_i,
  input  logic       bkup_ok_i,
  input  logic       pwr_key_i,
  input  logic       chg_det_i,
  input  logic       acc_clk_i,
  input  logic       rtc_alarm_i,
  input  logic       reg_rdy_i,
  input  logic       rfclk_rdy_i,
  input  logic       osc_rdy_i,
  input  logic       sw_sleep_i,
  input  logic       sw_off_i,
  input  logic       sw_off_cold_i,
  output logic [2:0] mode_o,
  output logic       reg_en_o,
  output logic       reg_sleep_o,
  output logic       tcxo_en_o,
  output logic       osc32_en_o,
  output logic       sys_rst_no
);
  localparam int unsigned WAKE_N = 3;

  pmode_e      mode_q, mode_d;
  logic [WAKE_N-1:0] ev;
  logic        pin_ev, any_wake, dly_done, wake_pend_q;

  pwr_edge_sync #(.N(WAKE_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({acc_clk_i, chg_det_i, pwr_key_i}),
    .ev_o  (ev)
  );

  pwr_rst_timer #(.DLY_CYC(DLY_CYC)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (mode_q == M_START),
    .rdy_i (reg_rdy_i & rfclk_rdy_i),
    .done_o(dly_done)
  );

  assign pin_ev   = |ev;
  assign any_wake = pin_ev | rtc_alarm_i;

  always_comb begin
    mode_d = mode_q;
    if (!main_ok_i) begin
      mode_d = bkup_ok_i ? M_BACKUP : M_NOSUP;
    end else begin
      case (mode_q)
        M_NOSUP:    mode_d = M_OFF_COLD;
        M_BACKUP:   mode_d = M_OFF_WARM;
        M_OFF_WARM: if (any_wake) mode_d = M_START;
        M_OFF_COLD: if (pin_ev)   mode_d = M_START;  // RTC stopped
        M_START:    if (dly_done) mode_d = M_ON;
        M_ON: begin
          if (sw_off_i)        mode_d = sw_off_cold_i ? M_OFF_COLD : M_OFF_WARM;
          else if (sw_sleep_i) mode_d = M_SLEEP;
        end
        M_SLEEP:    if (wake_pend_q && osc_rdy_i) mode_d = M_ON;
        default:    mode_d = M_NOSUP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_NOSUP;
      wake_pend_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      wake_pend_q <= (mode_q == M_SLEEP) && (wake_pend_q || any_wake);
    end
  end

  assign mode_o      = mode_q;
  assign reg_en_o    = (mode_q == M_START) || (mode_q == M_ON) || (mode_q == M_SLEEP);
  assign reg_sleep_o = (mode_q == M_SLEEP);
  assign tcxo_en_o   = (mode_q == M_START) || (mode_q == M_ON) ||
                       ((mode_q == M_SLEEP) && wake_pend_q);
  assign osc32_en_o  = (mode_q != M_NOSUP) && (mode_q != M_OFF_COLD);
  assign sys_rst_no  = (mode_q == M_ON) || (mode_q == M_SLEEP);

  // R2
  batt_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_ok_i |=> (mode_q == M_NOSUP || mode_q == M_BACKUP));
  // R3
  start_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_START && $past(mode_q) != M_START) |->
      ($past(mode_q) == M_OFF_WARM || $past(mode_q) == M_OFF_COLD));
  // R6
  on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ON && $past(mode_q) != M_ON && $past(mode_q) != M_SLEEP) |->
      ($past(mode_q) == M_START && $past(reg_rdy_i) && $past(rfclk_rdy_i)));
  // R8
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SLEEP && $past(mode_q) != M_SLEEP) |-> $past(mode_q) == M_ON);
  // R9
  sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ON && $past(mode_q) == M_SLEEP) |-> $past(osc_rdy_i));
endmodule

// File: tb/pwr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb_top;
  localparam logic [2:0] NOSUP = 3'd0, BACKUP = 3'd1, OFFW = 3'd2, OFFC = 3'd3,
                         START = 3'd4, ON = 3'd5, SLEEP = 3'd6;
  localparam int DLY = 524;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic main_ok = 0, bkup_ok = 0, key = 0, chg = 0, acc = 0, rtc = 0;
  logic reg_rdy = 0, rf_rdy = 0, osc_rdy = 0, sw_sleep = 0, sw_off = 0, sw_cold = 0;
  logic [2:0] mode_o;
  logic reg_en_o, reg_sleep_o, tcxo_en_o, osc32_en_o, sys_rst_no;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwr_mode_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .main_ok_i(main_ok), .bkup_ok_i(bkup_ok),
    .pwr_key_i(key), .chg_det_i(chg), .acc_clk_i(acc), .rtc_alarm_i(rtc),
    .reg_rdy_i(reg_rdy), .rfclk_rdy_i(rf_rdy), .osc_rdy_i(osc_rdy),
    .sw_sleep_i(sw_sleep), .sw_off_i(sw_off), .sw_off_cold_i(sw_cold),
    .mode_o(mode_o), .reg_en_o(reg_en_o), .reg_sleep_o(reg_sleep_o),
    .tcxo_en_o(tcxo_en_o), .osc32_en_o(osc32_en_o), .sys_rst_no(sys_rst_no)
  );

  function automatic logic [2:0] exp_drop(input logic bk);
    return bk ? BACKUP : NOSUP;
  endfunction
  function automatic logic [2:0] exp_return(input logic [2:0] m);
    return (m == BACKUP) ? OFFW : OFFC;
  endfunction
  function automatic logic [2:0] exp_wake(input logic [2:0] m, input int ch);
    if (m == OFFC && ch == 3) return OFFC;
    return START;
  endfunction
  function automatic logic e_osc32(input logic [2:0] m);
    return !(m == NOSUP || m == OFFC);
  endfunction
  function automatic logic e_reg(input logic [2:0] m);
    return (m == START || m == ON || m == SLEEP);
  endfunction
  function automatic logic e_rst(input logic [2:0] m);
    return (m == ON || m == SLEEP);
  endfunction
  function automatic logic e_tcxo(input logic [2:0] m);
    return (m == START || m == ON);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " osc32"}, {2'b0, osc32_en_o}, {2'b0, e_osc32(mode_o)});
    chk({tag, " reg_en"}, {2'b0, reg_en_o}, {2'b0, e_reg(mode_o)});
    chk({tag, " sys_rst"}, {2'b0, sys_rst_no}, {2'b0, e_rst(mode_o)});
    chk({tag, " reg_sleep"}, {2'b0, reg_sleep_o}, {2'b0, mode_o == SLEEP});
    chk({tag, " tcxo"}, {2'b0, tcxo_en_o}, {2'b0, e_tcxo(mode_o)});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] prev;
    void'($urandom(32'h5eed_0007));
    repeat (3) @(negedge clk);
    chk("R1 mode", mode_o, NOSUP);
    chk_outs("R1");
    rst_ni = 1'b1;
    tick(2);  chk("R2 stay nosup", mode_o, NOSUP);
    bkup_ok = 1; tick(1); chk("R2 backup", mode_o, BACKUP); chk_outs("R4 backup");
    main_ok = 1; tick(1); chk("R3 warm", mode_o, OFFW);
    tick(20); chk("R3 no battery boot", mode_o, OFFW); chk_outs("R4 warm");
    sw_sleep = 1; tick(1); sw_sleep = 0; chk("R8 sleep ignored", mode_o, OFFW);
    rtc = 1; tick(1); rtc = 0; chk("R5 rtc wake", mode_o, START); chk_outs("R4 start");
    tick(600); chk("R6 not ready", mode_o, START);
    reg_rdy = 1; rf_rdy = 1; tick(300);
    rf_rdy = 0; tick(1); rf_rdy = 1;
    tick(DLY - 1); chk("R6 before end", mode_o, START);
    tick(1); chk("R6 on", mode_o, ON); chk_outs("R4 on");
    key = 1; tick(5); key = 0; tick(5); chk("R7 key in on", mode_o, ON);
    osc_rdy = 0; sw_sleep = 1; tick(1); sw_sleep = 0;
    chk("R8 sleep", mode_o, SLEEP); chk_outs("R4 sleep");
    chg = 1; tick(10); chk("R9 wait osc", mode_o, SLEEP);
    chk("R9 tcxo", {2'b0, tcxo_en_o}, 3'd1);
    osc_rdy = 1; tick(1); chk("R9 resume", mode_o, ON);
    chg = 0; tick(3);
    // same cycle: off wins over sleep
    sw_off = 1; sw_sleep = 1; sw_cold = 1; tick(1); sw_off = 0; sw_sleep = 0; sw_cold = 0;
    chk("R10 cold off", mode_o, OFFC); chk_outs("R4 cold");
    rtc = 1; tick(1); rtc = 0; tick(3); chk("R5 rtc in cold", mode_o, OFFC);
    acc = 1; tick(1); acc = 0; tick(1); chk("R5 sync lat", mode_o, OFFC);
    tick(1); chk("R5 acc wake", mode_o, START);
    tick(DLY - 1); chk("R6 start", mode_o, START); tick(1); chk("R6 on2", mode_o, ON);
    sw_off = 1; tick(1); sw_off = 0; chk("R10 warm off", mode_o, OFFW);
    key = 1; tick(3); chk("R5 key wake", mode_o, START);
    tick(DLY); chk("R6 on3", mode_o, ON);
    osc_rdy = 0; sw_sleep = 1; tick(1); sw_sleep = 0; chk("R8 sleep2", mode_o, SLEEP);
    osc_rdy = 1; tick(10); chk("R7 held key", mode_o, SLEEP);
    chk("R7 held key tcxo", {2'b0, tcxo_en_o}, 3'd0);
    key = 0; tick(5); chk("R7 release", mode_o, SLEEP);
    key = 1; tick(4); chk("R9 key resume", mode_o, ON); key = 0;
    // same cycle: battery loss over software request
    main_ok = 0; sw_off = 1; tick(1); sw_off = 0; chk("R2 loss wins", mode_o, BACKUP);
    main_ok = 1; tick(1); chk("R3 return", mode_o, OFFW);

    for (int it = 0; it < 40; it++) begin
      logic bk;
      int ch;
      int n;
      bk = 1'($urandom % 2);
      ch = int'($urandom % 4);
      n  = int'($urandom % 400);
      main_ok = 0; bkup_ok = bk; tick(1);
      chk("R2 rand drop", mode_o, exp_drop(bk)); chk_outs("R4 rand");
      prev = mode_o;
      main_ok = 1; tick(1);
      chk("R3 rand return", mode_o, exp_return(prev));
      prev = mode_o;
      case (ch)
        0: key = 1;
        1: chg = 1;
        2: acc = 1;
        default: rtc = 1;
      endcase
      tick(1); key = 0; chg = 0; acc = 0; rtc = 0; tick(2);
      chk("R5 rand wake", mode_o, exp_wake(prev, ch));
      prev = mode_o;
      tick(n);
      chk("R6 rand hold", mode_o, prev);
    end
    summary();
    $finish;
  end
endmodule